// File: doc/BRIEF.md
# LFSR Self-Test Controller

This block is a self-contained self-test wrapper around a small combinational logic function. When a start request arrives, a maximal-length linear feedback shift register produces a deterministic pseudo-random input word every cycle for a fixed number of cycles. Each response of the logic under test is folded into a multiple-input signature register. Individual responses are never stored. When the run ends, the accumulated signature is compared against a known-good value supplied as a parameter. The block then raises a done flag and a pass flag.

The whole test is produced, compacted and judged on chip from a single start input. The only verdict is whether the signature matches. The final signature is also available on a readout port, which is useful for diagnosis. Because the compaction loses information, a faulty circuit can occasionally produce the good signature. This aliasing is an accepted limitation. A parameter can force one output bit of the logic under test to a constant, which gives verification a stuck-at fault model.

Top module: `bist_selftest`

## Requirements
- R1: After a synchronous active-low reset, and until the first accepted start, done_o and pass_o are 0 and sig_o is all zeros.
- R2: The pattern generator is an 8-bit shift register whose first pattern of a run is SEED. Each later pattern is {p[6:0], p[7]^p[5]^p[4]^p[3]}, which is the polynomial x^8+x^6+x^5+x^4+1. The register never holds zero.
- R3: For pattern x, the logic under test returns y, where y[i] = x[i] ^ (x[(i+1) mod 8] & x[(i+2) mod 8]). When FAULT_BIT is between 0 and 7, that bit of y is forced to FAULT_VAL.
- R4: An accepted start clears the signature to zero. For each response y, the signature then becomes {s[6:0], s[7]^s[5]^s[4]^s[3]} ^ y.
- R5: Exactly N_PATTERNS responses are compacted. done_o first reads 1 after the (N_PATTERNS+2)-th rising edge, counting the edge that samples start_i as the first.
- R6: When done_o is 1, pass_o is 1 exactly when the final signature equals GOLDEN. pass_o is never 1 while done_o is 0.
- R7: done_o, pass_o and sig_o hold their values while start_i stays low after completion. An accepted start drops done_o on the next edge.
- R8: start_i has no effect while a run or the comparison is in progress. Neither the latency nor the signature changes.
- R9: Repeated runs start from SEED and produce the same signature every time.
- R10: With N_PATTERNS = 1, the signature equals the response to SEED alone, and done_o appears after the third edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch request, honoured when idle or finished |
| done_o | output | 1 | Run complete, held until the next accepted start |
| pass_o | output | 1 | Signature matched GOLDEN |
| sig_o | output | W | Current or final signature readout |

## Verification
Any wrong pattern, wrong response bit or wrong compaction step stays hidden while the run is in progress. It shows up only when the run ends, as a final signature on sig_o that differs from the bench reference and, usually, as a pass_o of 0. A miscounted sequence shows immediately at the end of the run, as done_o rising a cycle early or late. A controller that honours a stray start shows as the same shift in latency. The bench compares each of these against values it computes from its own model, including a model of the stuck-at copy and of a one-pattern run.

// File: rtl/bist_pkg.sv
// Shared types for the self-test controller.
// Assumes: a two-bit encoding is enough for the sequencer state.
package bist_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_RUN  = 2'd1,
        SEQ_CMP  = 2'd2,
        SEQ_DONE = 2'd3
    } seq_state_t;

endpackage

// File: rtl/bist_patgen.sv
// Pseudo-random pattern source: a Fibonacci shift register stepping left.
// Assumes: SEED is nonzero and TAPS selects a maximal-length polynomial.
module bist_patgen #(
    parameter int           W     = 8,
    parameter logic [W-1:0] TAPS  = 8'hB8,
    parameter logic [W-1:0] SEED  = 8'h01
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    output logic [W-1:0] pat_o
);

    logic [W-1:0] q;
    logic         fb;

    // Feedback bit from the tapped stages.
    always_comb fb = ^(q & TAPS);

    // Reseed on reset or on load, otherwise advance while stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= SEED;
        else if (load_i) q <= SEED;
        else if (step_i) q <= {q[W-2:0], fb};
    end

    assign pat_o = q;

    AST_PATGEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        q != '0); // R2

endmodule

// File: rtl/bist_cut.sv
// Combinational logic under test, with an optional stuck-at output bit.
// Assumes: FAULT_BIT outside 0..W-1 means a fault-free circuit.
module bist_cut #(
    parameter int   W         = 8,
    parameter int   FAULT_BIT = -1,
    parameter logic FAULT_VAL = 1'b0
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == FAULT_BIT) begin : g_stuck
            assign y_o[i] = FAULT_VAL;
        end else begin : g_good
            assign y_o[i] = x_i[i] ^ (x_i[(i+1)%W] & x_i[(i+2)%W]);
        end
    end

endmodule

// File: rtl/bist_sigreg.sv
// Multiple-input signature register that folds one response word per step.
// Assumes: load_i and step_i are never high together.
module bist_sigreg #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         step_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sig_o
);

    logic [W-1:0] s;
    logic         fb;

    // Feedback bit from the tapped stages.
    always_comb fb = ^(s & TAPS);

    // Clear on reset or load, compact one response per step.
    always_ff @(posedge clk) begin
        if (!rst_n)      s <= '0;
        else if (load_i) s <= '0;
        else if (step_i) s <= {s[W-2:0], fb} ^ d_i;
    end

    assign sig_o = s;

endmodule

// File: rtl/bist_seq.sv
// Run sequencer: idle, run for N_PAT cycles, compare, then hold the result.
// Assumes: match_i is valid during the compare state.
module bist_seq
    import bist_pkg::*;
#(
    parameter int N_PAT = 255
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic match_i,
    output logic load_o,
    output logic step_o,
    output logic done_o,
    output logic pass_o
);

    localparam int            CNT_W = (N_PAT > 1) ? $clog2(N_PAT) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(N_PAT - 1);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    // A start is honoured only when idle or finished.
    always_comb accept = start_i && (state == SEQ_IDLE || state == SEQ_DONE);

    // State, pattern count and held verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            cnt    <= '0;
            done_o <= 1'b0;
            pass_o <= 1'b0;
        end else begin
            case (state)
                SEQ_IDLE, SEQ_DONE: begin
                    if (accept) begin
                        state  <= SEQ_RUN;
                        cnt    <= '0;
                        done_o <= 1'b0;
                        pass_o <= 1'b0;
                    end
                end
                SEQ_RUN: begin
                    if (cnt == LAST) state <= SEQ_CMP;
                    else             cnt   <= cnt + 1'b1;
                end
                SEQ_CMP: begin
                    done_o <= 1'b1;
                    pass_o <= match_i;
                    state  <= SEQ_DONE;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    assign load_o = accept;
    assign step_o = (state == SEQ_RUN);

    AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> done_o); // R6
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o); // R7
    AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN && cnt != LAST) |=> (state == SEQ_RUN)); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_RUN) |-> (cnt <= LAST)); // R5

endmodule

// File: rtl/bist_selftest.sv
// Top of the self-test wrapper: pattern source, logic under test,
// signature register and sequencer, with the golden comparison.
// Assumes: GOLDEN is the fault-free signature for SEED and N_PATTERNS.
module bist_selftest #(
    parameter int           W          = 8,
    parameter logic [W-1:0] TAPS       = 8'hB8,
    parameter logic [W-1:0] SEED       = 8'h01,
    parameter int           N_PATTERNS = 255,
    parameter logic [W-1:0] GOLDEN     = 8'h00,
    parameter int           FAULT_BIT  = -1,
    parameter logic         FAULT_VAL  = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    output logic         done_o,
    output logic         pass_o,
    output logic [W-1:0] sig_o
);

    logic         load;
    logic         step;
    logic         match;
    logic [W-1:0] pat;
    logic [W-1:0] resp;

    // Signature comparison against the stored good value.
    always_comb match = (sig_o == GOLDEN);

    bist_seq #(.N_PAT(N_PATTERNS)) seq_u (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .match_i(match),
        .load_o(load), .step_o(step), .done_o(done_o), .pass_o(pass_o)
    );

    bist_patgen #(.W(W), .TAPS(TAPS), .SEED(SEED)) gen_u (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step), .pat_o(pat)
    );

    bist_cut #(.W(W), .FAULT_BIT(FAULT_BIT), .FAULT_VAL(FAULT_VAL)) cut_u (
        .x_i(pat), .y_o(resp)
    );

    bist_sigreg #(.W(W), .TAPS(TAPS)) sig_u (
        .clk(clk), .rst_n(rst_n), .load_i(load), .step_i(step),
        .d_i(resp), .sig_o(sig_o)
    );

    AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sig_o == '0)); // R4
    AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> $stable(sig_o)); // R7

endmodule

// File: tb/bist_selftest_tb.sv
`timescale 1ns/1ps
// Bench: a fault-free unit, a stuck-at copy and a one-pattern unit, each
// checked against a signature model computed inside the bench.
module bist_selftest_tb_top;

    localparam int          NP   = 255;
    localparam logic [7:0]  SEED = 8'h5A;
    localparam int          FB   = 2;
    localparam logic        FV   = 1'b1;

    // Bench model of pattern source, logic under test and signature register.
    function automatic logic [7:0] ref_sig(input logic [7:0] seed, input int n,
                                           input int fbit, input logic fval);
        logic [7:0] p, s, y;
        p = seed;
        s = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < 8; i++)
                y[i] = (i == fbit) ? fval : (p[i] ^ (p[(i+1)%8] & p[(i+2)%8]));
            s = {s[6:0], s[7]^s[5]^s[4]^s[3]} ^ y;
            p = {p[6:0], p[7]^p[5]^p[4]^p[3]};
        end
        return s;
    endfunction

    localparam logic [7:0] GOLD   = ref_sig(SEED, NP, -1, 1'b0);
    localparam logic [7:0] FSIG   = ref_sig(SEED, NP, FB, FV);
    localparam logic [7:0] GOLD_S = ref_sig(SEED, 1, -1, 1'b0);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_a = 1'b0;
    logic start_s = 1'b0;
    logic done_a, pass_a, done_f, pass_f, done_s, pass_s;
    logic [7:0] sig_a, sig_f, sig_s;
    int nchk = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    bist_selftest #(.SEED(SEED), .N_PATTERNS(NP), .GOLDEN(GOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_a),
        .done_o(done_a), .pass_o(pass_a), .sig_o(sig_a));

    bist_selftest #(.SEED(SEED), .N_PATTERNS(NP), .GOLDEN(GOLD),
                    .FAULT_BIT(FB), .FAULT_VAL(FV)) dut_f (
        .clk(clk), .rst_n(rst_n), .start_i(start_a),
        .done_o(done_f), .pass_o(pass_f), .sig_o(sig_f));

    bist_selftest #(.SEED(SEED), .N_PATTERNS(1), .GOLDEN(GOLD_S)) dut_s (
        .clk(clk), .rst_n(rst_n), .start_i(start_s),
        .done_o(done_s), .pass_o(pass_s), .sig_o(sig_s));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One run of the long pair, with optional stray starts while busy.
    task automatic run_long(input bit spurious, input bit repeat_run);
        int k;
        logic [7:0] hs;
        @(negedge clk); start_a = 1'b1;
        @(negedge clk); start_a = 1'b0;
        k = 1;
        check(done_a == 1'b0, "R7 done drops after start", done_a, 0);
        while (k < 2000) begin
            if (spurious && k <= NP + 1 && ($urandom % 4) == 0) start_a = 1'b1;
            @(negedge clk);
            k++;
            start_a = 1'b0;
            if (done_a) break;
        end
        check(k == NP + 2, spurious ? "R8 latency with stray starts" : "R5 latency", k, NP + 2);
        check(sig_a == GOLD, repeat_run ? "R9 repeat signature" : "R2 R3 R4 signature", sig_a, GOLD);
        check(pass_a == 1'b1, "R6 pass on match", pass_a, 1);
        check(sig_f == FSIG, "R3 R4 stuck-at signature", sig_f, FSIG);
        check(pass_f == (FSIG == GOLD), "R6 stuck-at verdict", pass_f, int'(FSIG == GOLD));
        hs = sig_a;
        repeat ($urandom_range(3, 20)) @(negedge clk);
        check(done_a && pass_a && sig_a == hs, "R7 result held", {done_a, pass_a, sig_a}, {2'b11, hs});
    endtask

    // Watchdog: a hung run is a failure and still reaches the summary.
    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        int k;
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({done_a, pass_a, sig_a} == 10'd0, "R1 reset state", {done_a, pass_a, sig_a}, 0);
        check({done_s, pass_s, sig_s} == 10'd0, "R1 reset state short", {done_s, pass_s, sig_s}, 0);
        check(GOLD != FSIG, "R6 fault visible in model", FSIG, GOLD);
        repeat ($urandom_range(2, 10)) @(negedge clk);
        check(done_a == 1'b0 && sig_a == 8'h00, "R1 idle before start", {done_a, sig_a}, 0);

        // Directed: one clean run, then runs with stray starts and random gaps.
        run_long(1'b0, 1'b0);
        for (int r = 0; r < 5; r++) begin
            repeat ($urandom_range(0, 8)) @(negedge clk);
            run_long(r % 2 == 0, 1'b1);
        end

        // Boundary: one-pattern run.
        for (int r = 0; r < 3; r++) begin
            @(negedge clk); start_s = 1'b1;
            @(negedge clk); start_s = 1'b0;
            k = 1;
            while (!done_s && k < 50) begin @(negedge clk); k++; end
            check(k == 3, "R10 one-pattern latency", k, 3);
            check(sig_s == GOLD_S, "R10 one-pattern signature", sig_s, GOLD_S);
            check(pass_s == 1'b1, "R10 one-pattern pass", pass_s, 1);
            repeat ($urandom_range(1, 5)) @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule